// File: doc/BRIEF.md
# Pulse-Swallow Divider Control for a Two-Modulus Prescaler

This block sits behind an external prescaler that can divide by either P or P+1. It receives one strobe per prescaler output period. It counts those strobes with a main counter and a swallow counter that run together. From them it drives the modulus-select line that tells the prescaler which ratio to use. Once per complete count cycle it issues a feedback pulse, and that pulse goes on to a phase comparator.

During each cycle the swallow counter runs first. While it is non-zero the prescaler is told to divide by P+1. Once it is exhausted the prescaler is told to divide by P for the rest of the main count. The whole cycle therefore spans N·P + A periods of the prescaler's input. The programmed N and A values are sampled only when a cycle reloads, so a change in mid-cycle never mixes two settings. A setting that cannot be honoured is corrected, and a flag marks it. Such a setting is A greater than N, or N below the minimum.

Top module: `pls_divider_ctrl`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `mod_sel`, `fb_pulse` and `cfg_bad` are all 0.
- R2: With valid settings, the number of prescaler input clocks between two rising edges of `fb_pulse` equals N·P + A. This holds with a prescaler that divides by P+1 when `mod_sel` is 0 and by P when it is 1.
- R3: Within one cycle, `mod_sel` is 0 for exactly the first A prescaler periods. It is 1 for the remaining N−A periods, and it returns to 0 only at a reload.
- R4: When A is 0, `mod_sel` is 1 during the whole cycle.
- R5: When A equals N, `mod_sel` stays 0 for the whole cycle and the ratio is N·(P+1).
- R6: When A exceeds N, the block uses A = N for that cycle, and `cfg_bad` is 1 from that reload on.
- R7: When N is below 3, the block uses N = 3 for that cycle, and `cfg_bad` is 1 from that reload on.
- R8: Changes on `n_set` or `a_set` during a cycle do not affect that cycle. They take effect from the next reload.
- R9: `fb_pulse` rises on the clock edge that reloads the counters. It stays high for exactly the first prescaler period of the new cycle.
- R10: `cfg_bad` returns to 0 at the first reload whose settings are valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler input clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pre_tick | input | 1 | One-clock strobe, one per prescaler output period |
| n_set | input | 10 | Programmed main count N |
| a_set | input | 7 | Programmed swallow count A |
| mod_sel | output | 1 | Modulus select: 0 asks for P+1, 1 asks for P |
| fb_pulse | output | 1 | Divided feedback pulse, one per cycle |
| cfg_bad | output | 1 | Last reload used a corrected setting |

## Verification
On every cycle the assertions check the internal invariants. The swallow count never exceeds the main count, and the main count never reaches zero. Both counts hold still between strobes. The modulus line falls only together with a reload, the feedback pulse never lasts across two strobes, and the corrected settings always satisfy A ≤ N. The total divide ratio, the exact number of P+1 periods, the deferral of new settings to the next reload and the clearing of the error flag involve whole cycles and a prescaler model. Only the bench's scenarios can show these.

// File: rtl/pls_pkg.sv
package pls_pkg;
    localparam int unsigned PLS_N_W   = 10;
    localparam int unsigned PLS_A_W   = 7;
    localparam int unsigned PLS_N_MIN = 3;
endpackage

// File: rtl/pls_cfg_guard.sv
module pls_cfg_guard #(
    parameter int unsigned N_W   = pls_pkg::PLS_N_W,
    parameter int unsigned A_W   = pls_pkg::PLS_A_W,
    parameter int unsigned N_MIN = pls_pkg::PLS_N_MIN
) (
    input  logic [N_W-1:0] n_raw,
    input  logic [A_W-1:0] a_raw,
    output logic [N_W-1:0] n_eff,
    output logic [A_W-1:0] a_eff,
    output logic           bad
);
    localparam logic [N_W-1:0] N_FLOOR = N_W'(N_MIN);

    logic [N_W-1:0] a_wide;
    logic           n_low;
    logic           a_high;

    always_comb begin
        a_wide = N_W'(a_raw);
        n_low  = (n_raw < N_FLOOR);
        n_eff  = n_low ? N_FLOOR : n_raw;
        a_high = (a_wide > n_eff);
        a_eff  = a_high ? A_W'(n_eff) : a_raw;
        bad    = n_low | a_high;
    end

    // R6: corrected swallow value never exceeds corrected main value
    always_comb begin
        assert_eff_order_R6: assert (N_W'(a_eff) <= n_eff);
    end
endmodule

// File: rtl/pls_count_core.sv
module pls_count_core #(
    parameter int unsigned N_W = pls_pkg::PLS_N_W,
    parameter int unsigned A_W = pls_pkg::PLS_A_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           tick,
    input  logic [N_W-1:0] n_load,
    input  logic [A_W-1:0] a_load,
    input  logic           bad_load,
    output logic           mc,
    output logic           fv,
    output logic           err
);
    typedef struct packed {
        logic [N_W-1:0] n_cnt;
        logic [A_W-1:0] a_cnt;
        logic           mc;
        logic           fv;
        logic           err;
        logic           live;
    } core_state_t;

    localparam logic [N_W-1:0] N_ONE = N_W'(1);

    core_state_t st_q, st_d;

    always_comb begin
        st_d = st_q;
        if (!st_q.live || (tick && st_q.n_cnt == N_ONE)) begin
            st_d.n_cnt = n_load;
            st_d.a_cnt = a_load;
            st_d.mc    = (a_load == '0);
            st_d.err   = bad_load;
            st_d.fv    = st_q.live;
            st_d.live  = 1'b1;
        end else if (tick) begin
            st_d.n_cnt = st_q.n_cnt - N_ONE;
            if (st_q.a_cnt != '0) begin
                st_d.a_cnt = st_q.a_cnt - A_W'(1);
            end
            st_d.mc = (st_d.a_cnt == '0);
            st_d.fv = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mc  = st_q.mc;
    assign fv  = st_q.fv;
    assign err = st_q.err;

    // R6: swallow count bounded by main count
    assert_cnt_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live |-> (N_W'(st_q.a_cnt) <= st_q.n_cnt));
    // R7: main count never empty once running
    assert_n_nonzero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.live |-> (st_q.n_cnt != '0));
    // R3: modulus line drops only at a reload
    assert_mc_fall_reload_R3: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.mc) |-> st_q.fv);
    // R8: counters hold between strobes
    assert_hold_no_tick_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.live && !tick) |=> ($stable(st_q.n_cnt) && $stable(st_q.a_cnt)));
    // R9: feedback pulse ends at the next strobe
    assert_fv_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.fv && tick) |=> !st_q.fv);
endmodule

// File: rtl/pls_divider_ctrl.sv
module pls_divider_ctrl #(
    parameter int unsigned N_W   = pls_pkg::PLS_N_W,
    parameter int unsigned A_W   = pls_pkg::PLS_A_W,
    parameter int unsigned N_MIN = pls_pkg::PLS_N_MIN
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           pre_tick,
    input  logic [N_W-1:0] n_set,
    input  logic [A_W-1:0] a_set,
    output logic           mod_sel,
    output logic           fb_pulse,
    output logic           cfg_bad
);
    logic [N_W-1:0] n_fix;
    logic [A_W-1:0] a_fix;
    logic           fix_bad;

    pls_cfg_guard #(.N_W(N_W), .A_W(A_W), .N_MIN(N_MIN)) u_guard (
        .n_raw (n_set),
        .a_raw (a_set),
        .n_eff (n_fix),
        .a_eff (a_fix),
        .bad   (fix_bad)
    );

    pls_count_core #(.N_W(N_W), .A_W(A_W)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (pre_tick),
        .n_load   (n_fix),
        .a_load   (a_fix),
        .bad_load (fix_bad),
        .mc       (mod_sel),
        .fv       (fb_pulse),
        .err      (cfg_bad)
    );
endmodule

// File: tb/sim_pls_divider_ctrl.sv
`timescale 1ns/1ps
module sim_pls_divider_ctrl;
    localparam int PDIV = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pre_tick = 1'b0;
    logic [9:0] n_set = 10'd5;
    logic [6:0] a_set = 7'd2;
    logic       mod_sel, fb_pulse, cfg_bad;
    logic       pre_run = 1'b0;
    int         pcnt = 0;
    int         n_checks = 0;
    int         n_fails = 0;
    bit         done = 1'b0;

    always #2.5 clk = ~clk;

    pls_divider_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .pre_tick(pre_tick),
        .n_set(n_set), .a_set(a_set),
        .mod_sel(mod_sel), .fb_pulse(fb_pulse), .cfg_bad(cfg_bad)
    );

    // behavioural prescaler: P+1 when mod_sel is 0, P when 1
    always @(negedge clk) begin
        if (!pre_run) begin
            pre_tick = 1'b0;
            pcnt = 0;
        end else if (pre_tick || pcnt == 0) begin
            pre_tick = 1'b0;
            pcnt = (mod_sel ? PDIV : PDIV + 1) - 1;
        end else if (pcnt == 1) begin
            pre_tick = 1'b1;
        end else begin
            pcnt = pcnt - 1;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int exp_ratio(input int n, input int a);
        int ne = (n < 3) ? 3 : n;
        int ae = (a > ne) ? ne : a;
        return ne * PDIV + ae;
    endfunction

    task automatic restart(input int n, input int a);
        @(negedge clk);
        pre_run = 1'b0;
        rst_n = 1'b0;
        n_set = 10'(n);
        a_set = 7'(a);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        pre_run = 1'b1;
    endtask

    // waits for a rising feedback edge, then measures the following cycle
    task automatic get_cycle(output int per, output int low, output int hi);
        logic prev = 1'b1;
        int guard = 0;
        while (guard < 20000) begin
            @(negedge clk);
            guard++;
            if (fb_pulse && !prev) break;
            prev = fb_pulse;
        end
        per = 0; low = 0; hi = 0;
        prev = fb_pulse;
        while (per < 20000) begin
            per++;
            if (!mod_sel) low++;
            if (fb_pulse) hi++;
            @(negedge clk);
            if (fb_pulse && !prev) break;
            prev = fb_pulse;
        end
    endtask

    task automatic t_reset;
        @(negedge clk);
        rst_n = 1'b0;
        pre_run = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 mod_sel in reset", mod_sel, 0);
        check("R1 fb_pulse in reset", fb_pulse, 0);
        check("R1 cfg_bad in reset", cfg_bad, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 fb_pulse after first load", fb_pulse, 0);
    endtask

    task automatic t_ratio(input int n, input int a);
        int per, low, hi;
        restart(n, a);
        get_cycle(per, low, hi);
        check($sformatf("R2 ratio N=%0d A=%0d", n, a), per, exp_ratio(n, a));
        check($sformatf("R3 P+1 clocks N=%0d A=%0d", n, a), low, a * (PDIV + 1));
        check("R9 fb_pulse width", hi, (a > 0) ? PDIV + 1 : PDIV);
        check("R10 cfg_bad on valid setting", cfg_bad, 0);
    endtask

    task automatic t_swallow_zero;
        int per, low, hi;
        restart(7, 0);
        get_cycle(per, low, hi);
        check("R4 mod_sel low clocks with A=0", low, 0);
        check("R4 ratio with A=0", per, 7 * PDIV);
    endtask

    task automatic t_swallow_full;
        int per, low, hi;
        restart(9, 9);
        get_cycle(per, low, hi);
        check("R5 mod_sel low whole cycle", low, per);
        check("R5 ratio N(P+1)", per, 9 * (PDIV + 1));
    endtask

    task automatic t_a_over_n;
        int per, low, hi;
        restart(4, 9);
        get_cycle(per, low, hi);
        check("R6 ratio with A clamped", per, 4 * (PDIV + 1));
        check("R6 cfg_bad set", cfg_bad, 1);
    endtask

    task automatic t_n_small;
        int per, low, hi;
        restart(1, 0);
        get_cycle(per, low, hi);
        check("R7 ratio with N clamped", per, 3 * PDIV);
        check("R7 cfg_bad set", cfg_bad, 1);
    endtask

    task automatic t_deferred;
        int per, low, hi, k;
        logic prev;
        restart(6, 2);
        get_cycle(per, low, hi);
        k = 0;
        prev = fb_pulse;
        while (k < 20000) begin
            k++;
            if (k == 3) begin
                n_set = 10'd4;
                a_set = 7'd1;
            end
            @(negedge clk);
            if (fb_pulse && !prev) break;
            prev = fb_pulse;
        end
        check("R8 cycle keeps old setting", k, exp_ratio(6, 2));
        get_cycle(per, low, hi);
        check("R8 next cycle uses new setting", per, exp_ratio(4, 1));
    endtask

    task automatic t_err_clear;
        int per, low, hi;
        restart(4, 20);
        get_cycle(per, low, hi);
        check("R6 cfg_bad before fix", cfg_bad, 1);
        n_set = 10'd8;
        a_set = 7'd3;
        get_cycle(per, low, hi);
        get_cycle(per, low, hi);
        check("R10 cfg_bad cleared", cfg_bad, 0);
        check("R10 ratio after fix", per, exp_ratio(8, 3));
    endtask

    initial begin
        t_reset();
        t_ratio(5, 2);
        t_ratio(3, 1);
        t_ratio(100, 77);
        t_swallow_zero();
        t_swallow_full();
        t_a_over_n();
        t_n_small();
        t_deferred();
        t_err_clear();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
            $finish;
        end
    end
endmodule